// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral DMA request lines and the request inputs of a bank of DMA channels. Each request line owns one mapping register that holds an enable flag and a 5-bit channel number. A request line whose mapping is enabled is steered to the channel it names, and that channel's acknowledge is steered back to the line. Software programs the mapping through a simple register bus whose addresses are split into two windows by request number.

Request and acknowledge routing is purely combinational. A register write changes the routing from the next clock edge onward. When several enabled lines name the same channel, their requests merge into that channel. The channel's acknowledge then goes to the lowest-numbered line among those that are requesting at that moment. Choosing which channel runs, and moving data, are the job of other blocks.

Top module: `req_chan_mapper`

## Requirements
- R1: After reset every mapping register reads 0, every channel request output is 0 and every peripheral acknowledge is 0, whatever the request inputs are.
- R2: For request number r below 64, the mapping register sits at byte address 0x100 + 4*r. Bit 7 is the enable flag and bits [4:0] are the channel number. On read, every other bit is 0, and the register returns the last enable flag and channel number written to it.
- R3: For request number r of 64 or above, the mapping register sits at byte address 0x1100 + 4*(r-64). A write in one window never changes a register in the other window.
- R4: A write whose address is not word aligned, falls outside both windows, or names a request number of NUM_REQ or more changes no register. A read of such an address returns 0.
- R5: A request line whose enable flag is 0 never raises any channel request and never receives an acknowledge.
- R6: For an enabled line naming channel c, with c below NUM_CH, ch_req[c] follows that line's request in the same cycle.
- R7: An enabled line naming a channel number of NUM_CH or more raises no channel request and receives no acknowledge.
- R8: When several enabled lines name the same channel, that channel's request is the OR of their requests.
- R9: Each channel's acknowledge reaches only the lowest-numbered line that is requesting and is mapped to that channel. A line that is not requesting never receives an acknowledge.
- R10: A mapping write is sampled on the rising clock edge while bus_sel and bus_wr are high. Routing before that edge uses the old mapping, and routing after it uses the new one. Read data is combinational while bus_sel is high and bus_wr is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data (bit 7 enable, bits [4:0] channel) |
| bus_rdata | output | 32 | Read data of the addressed mapping register |
| peri_req | input | NUM_REQ | Peripheral request lines |
| peri_ack | output | NUM_REQ | Acknowledge returned to each peripheral |
| ch_req | output | NUM_CH | Request presented to each channel |
| ch_ack | input | NUM_CH | Acknowledge from each channel |

## Verification
The bench builds the block with NUM_REQ = 68 and NUM_CH = 8. With 68 request lines, the upper window holds a few real registers and also has addresses past the last line, so both out-of-range writes and cross-window aliasing can be probed. With only eight channels, a 5-bit channel field can name a channel that does not exist, which tests the rule that such a mapping is dropped. Lines from both windows are then mapped onto one shared channel so that merged requests and lowest-number acknowledge steering can be observed.

// File: rtl/req_map_pkg.sv
package req_map_pkg;
    localparam int CH_FIELD_W = 5;
    localparam int EN_BIT     = 7;
    localparam int IDX_W      = 7;   // 64 slots per window, two windows
    localparam int ADDR_W     = 13;
    localparam logic [4:0] LO_PAGE = 5'h01;  // 0x100 .. 0x1FF
    localparam logic [4:0] HI_PAGE = 5'h11;  // 0x1100 .. 0x11FF

    typedef struct packed {
        logic                  en;
        logic [CH_FIELD_W-1:0] ch;
    } map_t;
endpackage

// File: rtl/req_map_decode.sv
module req_map_decode
    import req_map_pkg::*;
#(
    parameter int NUM_REQ = 96
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [7:0] REQ_LIMIT = 8'(NUM_REQ);

    logic [4:0]       page;
    logic             lo_win;
    logic             hi_win;
    logic [IDX_W-1:0] idx_full;

    always_comb begin
        page     = addr_i[ADDR_W-1:8];
        lo_win   = (page == LO_PAGE);
        hi_win   = (page == HI_PAGE);
        idx_full = {hi_win, addr_i[7:2]};
        hit_o    = (lo_win || hi_win) && (addr_i[1:0] == 2'b00)
                   && ({1'b0, idx_full} < REQ_LIMIT);
        idx_o    = idx_full;
    end

    always_comb begin
        if (hit_o) begin
            assert_hit_aligned_R4: assert (addr_i[1:0] == 2'b00);
        end
    end
endmodule

// File: rtl/req_map_regs.sv
module req_map_regs
    import req_map_pkg::*;
#(
    parameter int NUM_REQ = 96
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  map_t                   wdata_i,
    output map_t [NUM_REQ-1:0]     maps_o
);
    typedef struct packed {
        map_t [NUM_REQ-1:0] maps;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (wr_en_i && (idx_i == IDX_W'(r))) begin
                st_d.maps[r] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign maps_o = st_q.maps;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (maps_o[$past(idx_i)] == $past(wdata_i)));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(maps_o));
endmodule

// File: rtl/req_map_xbar.sv
module req_map_xbar
    import req_map_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  map_t [NUM_REQ-1:0] maps_i,
    input  logic [NUM_REQ-1:0] peri_req_i,
    input  logic [NUM_CH-1:0]  ch_ack_i,
    output logic [NUM_CH-1:0]  ch_req_o,
    output logic [NUM_REQ-1:0] peri_ack_o
);
    logic [NUM_REQ-1:0] sel   [NUM_CH];
    logic [NUM_REQ-1:0] grant [NUM_CH];

    always_comb begin
        logic found;
        peri_ack_o = '0;
        ch_req_o   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            found    = 1'b0;
            sel[c]   = '0;
            grant[c] = '0;
            for (int r = 0; r < NUM_REQ; r++) begin
                sel[c][r] = maps_i[r].en && peri_req_i[r]
                            && (maps_i[r].ch == CH_FIELD_W'(c));
                if (sel[c][r] && !found) begin
                    grant[c][r] = 1'b1;
                    found       = 1'b1;
                end
            end
            ch_req_o[c] = |sel[c];
            if (ch_ack_i[c]) peri_ack_o = peri_ack_o | grant[c];
        end
    end

    assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (peri_ack_o & ~peri_req_i) == '0);

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chk
        assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[gc]));
        assert_req_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_req_o[gc] |-> (|peri_req_i));
    end
endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper
    import req_map_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [12:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_REQ-1:0] peri_req,
    output logic [NUM_REQ-1:0] peri_ack,
    output logic [NUM_CH-1:0]  ch_req,
    input  logic [NUM_CH-1:0]  ch_ack
);
    logic               hit;
    logic [IDX_W-1:0]   idx;
    logic               wr_en;
    map_t               wmap;
    map_t               rmap;
    map_t [NUM_REQ-1:0] maps;
    logic               unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:8], bus_wdata[6:5]};

    req_map_decode #(.NUM_REQ(NUM_REQ)) u_dec (
        .addr_i (bus_addr),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    assign wr_en = bus_sel && bus_wr && hit;
    assign wmap  = '{en: bus_wdata[EN_BIT], ch: bus_wdata[CH_FIELD_W-1:0]};

    req_map_regs #(.NUM_REQ(NUM_REQ)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .idx_i   (idx),
        .wdata_i (wmap),
        .maps_o  (maps)
    );

    always_comb begin
        rmap = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (idx == IDX_W'(r)) rmap = maps[r];
        end
        bus_rdata = '0;
        if (bus_sel && !bus_wr && hit) begin
            bus_rdata[EN_BIT]           = rmap.en;
            bus_rdata[CH_FIELD_W-1:0]   = rmap.ch;
        end
    end

    req_map_xbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
        .clk        (clk),
        .rst_n      (rst_n),
        .maps_i     (maps),
        .peri_req_i (peri_req),
        .ch_ack_i   (ch_ack),
        .ch_req_o   (ch_req),
        .peri_ack_o (peri_ack)
    );

    assert_rdata_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~32'h0000_009F) == '0);
endmodule

// File: tb/req_chan_mapper_tb_top.sv
module req_chan_mapper_tb_top;
    localparam int NR = 68;
    localparam int NC = 8;
    localparam int NT = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [12:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NR-1:0] peri_req = '0;
    logic [NR-1:0] peri_ack;
    logic [NC-1:0] ch_req;
    logic [NC-1:0] ch_ack = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    req_chan_mapper #(.NUM_REQ(NR), .NUM_CH(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peri_req(peri_req), .peri_ack(peri_ack), .ch_req(ch_req), .ch_ack(ch_ack)
    );

    // write address, write data, read-back address, expected read data
    localparam logic [12:0] T_WA [NT] = '{13'h0100, 13'h0104, 13'h1100, 13'h110C,
                                          13'h1110, 13'h0102, 13'h0200, 13'h01FC, 13'h1104};
    localparam logic [31:0] T_WD [NT] = '{32'h83, 32'hFFFF_FF65, 32'h9F, 32'h82,
                                          32'h81, 32'h81, 32'h81, 32'h87, 32'h84};
    localparam logic [12:0] T_RA [NT] = '{13'h0100, 13'h0104, 13'h1100, 13'h110C,
                                          13'h1110, 13'h0100, 13'h0200, 13'h01FC, 13'h0104};
    localparam logic [31:0] T_EX [NT] = '{32'h83, 32'h05, 32'h9F, 32'h82,
                                          32'h00, 32'h83, 32'h00, 32'h87, 32'h05};
    localparam string T_RQ [NT] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R4", "R2", "R3"};

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [31:0]   rd;
        logic [NR-1:0] ea;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all requests high, all acks high
        peri_req = '1; ch_ack = '1;
        #1;
        check("R1", 128'(ch_req), 128'(0));
        check("R1", 128'(peri_ack), 128'(0));
        bus_read(13'h1100, rd);
        check("R1", 128'(rd), 128'(0));
        peri_req = '0; ch_ack = '0;

        // table walk: register map and ignored writes
        for (int i = 0; i < NT; i++) begin
            bus_write(T_WA[i], T_WD[i]);
            bus_read(T_RA[i], rd);
            check(T_RQ[i], 128'(rd), 128'(T_EX[i]));
        end

        // R6: line 0 -> ch3
        @(negedge clk);
        peri_req = '0; peri_req[0] = 1'b1; ch_ack = 8'h08;
        #1;
        check("R6", 128'(ch_req), 128'(8'h08));
        ea = '0; ea[0] = 1'b1;
        check("R9", 128'(peri_ack), 128'(ea));

        // R5: line 1 not enabled
        peri_req = '0; peri_req[1] = 1'b1; ch_ack = '1;
        #1;
        check("R5", 128'(ch_req), 128'(0));
        check("R5", 128'(peri_ack), 128'(0));

        // R7: line 64 names ch31, absent
        peri_req = '0; peri_req[64] = 1'b1;
        #1;
        check("R7", 128'(ch_req), 128'(0));
        check("R7", 128'(peri_ack), 128'(0));

        // R6: upper window line 67 -> ch2
        peri_req = '0; peri_req[67] = 1'b1; ch_ack = '0;
        #1;
        check("R6", 128'(ch_req), 128'(8'h04));

        // R8 / R9: lines 10 and 66 share ch3
        peri_req = '0;
        bus_write(13'h0128, 32'h83);
        bus_write(13'h1108, 32'h83);
        @(negedge clk);
        peri_req[10] = 1'b1; peri_req[66] = 1'b1; ch_ack = 8'h08;
        #1;
        check("R8", 128'(ch_req), 128'(8'h08));
        ea = '0; ea[10] = 1'b1;
        check("R9", 128'(peri_ack), 128'(ea));
        peri_req[10] = 1'b0;
        #1;
        check("R8", 128'(ch_req), 128'(8'h08));
        ea = '0; ea[66] = 1'b1;
        check("R9", 128'(peri_ack), 128'(ea));
        ch_ack = '0;
        #1;
        check("R9", 128'(peri_ack), 128'(0));

        // R10: unmapping line 0 takes effect at the write edge
        peri_req = '0; peri_req[0] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 13'h0100; bus_wdata = 32'h0;
        #1;
        check("R10", 128'(ch_req), 128'(8'h08));
        @(posedge clk);
        #1;
        check("R10", 128'(ch_req), 128'(0));
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;

        // R1: reset in mid run clears the mapping
        peri_req = '0; peri_req[67] = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R1", 128'(ch_req), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(13'h110C, rd);
        check("R1", 128'(rd), 128'(0));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule